// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Code Unit for 8-Bit Memory Words

This unit protects an 8-bit memory word with a Hamming code that is extended by a parity bit over the whole word. Its encode side is purely combinational. It turns the data byte into a 13-bit word that is ready to be written into storage. Inside that word, bit index `n` (1 to 12) holds code position `n`. Index 0 holds the parity bit that covers the whole word. Four check bits sit at the positions that are powers of two. The data bits fill all of the remaining positions.

The decode side accepts a 13-bit word that has been read back from storage, qualified by a valid strobe. It recomputes the check bits and combines them with the stored check bits to form a 4-bit syndrome. It also tests the parity of the whole word. From these two results each word falls into exactly one of five outcome classes:

- `CLS_CLEAN`: no error.
- `CLS_SINGLE`: one flipped bit at the position the syndrome names, which is repaired.
- `CLS_PARBIT`: only the whole-word parity bit is flipped.
- `CLS_DOUBLE`: two flipped bits, left unrepaired.
- `CLS_RANGE`: the syndrome names a position that does not exist, left unrepaired.

The class is worked out combinationally. It is then registered together with the data, the two flags and the syndrome, so every result appears one clock cycle after its strobe. The class register changes at every accepted word, and any class can follow any other. When no word is offered, every output holds its value and only the valid strobe drops.

Top module: `ecc_secded_unit`

## Requirements
- R1: In `enc_word`, bit index n (1..12) is code position n. Check bits sit at indices 1, 2, 4 and 8. Data bits 0..7 sit at indices 3, 5, 6, 7, 9, 10, 11 and 12 in that order. For data 8'hFF the word is 13'h1EEE.
- R2: The check bit at index 2^k equals the XOR of the data bits whose index has bit k set.
- R3: Bit 0 of `enc_word` is chosen so that the 13-bit word always holds an even number of ones.
- R4: A word taken unmodified from the encoder decodes to the original data, with `dec_syndrome` = 0 and both flags low.
- R5: A word with exactly one flipped bit at index n in 1..12 decodes with `dec_syndrome` = n, `dec_corrected` = 1, `dec_uncorrectable` = 0, and the original data.
- R6: A word whose only flipped bit is index 0 decodes with `dec_syndrome` = 0, `dec_corrected` = 1, `dec_uncorrectable` = 0, and the original data.
- R7: A word with exactly two flipped bits decodes with `dec_uncorrectable` = 1 and `dec_corrected` = 0. Its syndrome is the XOR of the two indices, and its data is taken from the received word unaltered.
- R8: When the parity of the whole word fails and the syndrome is 13, 14 or 15, the result is `dec_uncorrectable` = 1, `dec_corrected` = 0, and data taken unaltered from the received word.
- R9: `dec_valid_out` is high exactly one cycle after each cycle in which `dec_valid_in` is high. While `dec_valid_in` is low, the data, flags and syndrome hold their values.
- R10: While `rst_n` is low, all decoder outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data | input | 8 | Data byte to encode |
| enc_word | output | 13 | Encoded word, combinational |
| dec_valid_in | input | 1 | Strobe qualifying `dec_word` |
| dec_word | input | 13 | Word read back from storage |
| dec_valid_out | output | 1 | Result strobe, one cycle after `dec_valid_in` |
| dec_data | output | 8 | Corrected (or raw, if uncorrectable) data |
| dec_corrected | output | 1 | A single error was repaired |
| dec_uncorrectable | output | 1 | Double error or out-of-range syndrome |
| dec_syndrome | output | 4 | Syndrome of the received word |

## Verification
The embedded assertions check several rules on every cycle:

- The two flags never rise together.
- A zero syndrome never yields an uncorrectable result.
- A syndrome above 12 is never reported as corrected.
- The result strobe follows the input strobe by exactly one cycle.
- The held outputs stay stable while no word is offered.

Only the bench's scenarios can show that each result is correct. That means the exact check-bit values and layout, repair of every one of the 13 bit positions, double-error syndromes equal to the XOR of the two indices, and the raw data passed through for unrepairable words.

// File: rtl/ecc_secded_pkg.sv
package ecc_secded_pkg;

    // Smallest number of check bits with 2^k >= m + k + 1
    function automatic int calc_chk_bits(input int m);
        int k;
        k = 1;
        while ((1 << k) < (m + k + 1)) k++;
        return k;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Code position of data bit i: the i-th position that is not a power of two
    function automatic int data_pos(input int i);
        int p;
        int seen;
        p = 0;
        seen = -1;
        while (seen < i) begin
            p++;
            if (!is_pow2(p)) seen++;
        end
        return p;
    endfunction

    typedef enum logic [2:0] {
        CLS_CLEAN,
        CLS_SINGLE,
        CLS_PARBIT,
        CLS_DOUBLE,
        CLS_RANGE
    } ecc_class_e;

endpackage

// File: rtl/secded_encode.sv
module secded_encode
    import ecc_secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = calc_chk_bits(DATA_W),
    localparam int NPOS  = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [NPOS:0]     word_o
);

    logic [NPOS:0] code;

    always_comb begin
        code = '0;
        for (int i = 0; i < DATA_W; i++) begin
            code[data_pos(i)] = data_i[i];
        end
        for (int k = 0; k < CHK_W; k++) begin
            for (int p = 1; p <= NPOS; p++) begin
                if (((p >> k) & 1) == 1 && !is_pow2(p)) begin
                    code[1 << k] = code[1 << k] ^ code[p];
                end
            end
        end
        code[0] = ^code[NPOS:1];
    end

    assign word_o = code;

endmodule

// File: rtl/secded_check.sv
module secded_check
    import ecc_secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = calc_chk_bits(DATA_W),
    localparam int NPOS  = DATA_W + CHK_W
) (
    input  logic [NPOS:0]      word_i,
    output logic [CHK_W-1:0]   syndrome_o,
    output logic               par_fail_o
);

    // Stored check bit XOR recomputed check bit equals parity over the whole group
    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        always_comb begin
            syndrome_o[k] = 1'b0;
            for (int p = 1; p <= NPOS; p++) begin
                if (((p >> k) & 1) == 1) syndrome_o[k] = syndrome_o[k] ^ word_i[p];
            end
        end
    end

    assign par_fail_o = ^word_i;

endmodule

// File: rtl/secded_decode_reg.sv
module secded_decode_reg
    import ecc_secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = calc_chk_bits(DATA_W),
    localparam int NPOS  = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [NPOS:0]     word_i,
    input  logic [CHK_W-1:0]  syndrome_i,
    input  logic              par_fail_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              corrected_o,
    output logic              uncorr_o,
    output logic [CHK_W-1:0]  syndrome_o
);

    ecc_class_e          cls_d, cls_q;
    logic [NPOS:0]       fixed_word;
    logic [DATA_W-1:0]   data_d;

    // Classification of the incoming word
    always_comb begin
        if (!par_fail_i) begin
            cls_d = (syndrome_i == '0) ? CLS_CLEAN : CLS_DOUBLE;
        end else if (syndrome_i == '0) begin
            cls_d = CLS_PARBIT;
        end else if (int'(syndrome_i) > NPOS) begin
            cls_d = CLS_RANGE;
        end else begin
            cls_d = CLS_SINGLE;
        end
    end

    always_comb begin
        fixed_word = word_i;
        if (cls_d == CLS_SINGLE) begin
            fixed_word = word_i ^ ((NPOS + 1)'(1) << syndrome_i);
        end
        for (int i = 0; i < DATA_W; i++) begin
            data_d[i] = fixed_word[data_pos(i)];
        end
    end

    // Class register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= CLS_CLEAN;
        end else if (valid_i) begin
            cls_q <= cls_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            data_o     <= '0;
            syndrome_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o     <= data_d;
                syndrome_o <= syndrome_i;
            end
        end
    end

    // Flags decoded from the registered class
    always_comb begin
        corrected_o = 1'b0;
        uncorr_o    = 1'b0;
        unique case (cls_q)
            CLS_CLEAN:  ;
            CLS_SINGLE: corrected_o = 1'b1;
            CLS_PARBIT: corrected_o = 1'b1;
            CLS_DOUBLE: uncorr_o    = 1'b1;
            CLS_RANGE:  uncorr_o    = 1'b1;
            default:    ;
        endcase
    end

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(corrected_o && uncorr_o));

    // R4
    zero_syn_not_uncorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && syndrome_o == '0) |-> !uncorr_o);

    // R8
    range_syn_not_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && int'(syndrome_o) > NPOS) |-> (uncorr_o && !corrected_o));

    // R9
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(data_o) && $stable(syndrome_o)));

endmodule

// File: rtl/ecc_secded_unit.sv
module ecc_secded_unit
    import ecc_secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = calc_chk_bits(DATA_W),
    localparam int NPOS  = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data,
    output logic [NPOS:0]     enc_word,
    input  logic              dec_valid_in,
    input  logic [NPOS:0]     dec_word,
    output logic              dec_valid_out,
    output logic [DATA_W-1:0] dec_data,
    output logic              dec_corrected,
    output logic              dec_uncorrectable,
    output logic [CHK_W-1:0]  dec_syndrome
);

    logic [CHK_W-1:0] syn;
    logic             par_fail;

    secded_encode #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data),
        .word_o (enc_word)
    );

    secded_check #(.DATA_W(DATA_W)) u_chk (
        .word_i     (dec_word),
        .syndrome_o (syn),
        .par_fail_o (par_fail)
    );

    secded_decode_reg #(.DATA_W(DATA_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (dec_valid_in),
        .word_i      (dec_word),
        .syndrome_i  (syn),
        .par_fail_i  (par_fail),
        .valid_o     (dec_valid_out),
        .data_o      (dec_data),
        .corrected_o (dec_corrected),
        .uncorr_o    (dec_uncorrectable),
        .syndrome_o  (dec_syndrome)
    );

    // R3
    enc_even_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^enc_word) == 1'b0);

endmodule

// File: tb/tb_ecc_secded_unit.sv
module tb_ecc_secded_unit;

    localparam int DW = 8;
    localparam int CW = 4;
    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] enc_data = '0;
    logic [NP:0]   enc_word;
    logic          dec_valid_in = 1'b0;
    logic [NP:0]   dec_word = '0;
    logic          dec_valid_out;
    logic [DW-1:0] dec_data;
    logic          dec_corrected;
    logic          dec_uncorrectable;
    logic [CW-1:0] dec_syndrome;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int pos_tab [DW] = '{3, 5, 6, 7, 9, 10, 11, 12};

    always #5 clk = ~clk;

    ecc_secded_unit dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .enc_data          (enc_data),
        .enc_word          (enc_word),
        .dec_valid_in      (dec_valid_in),
        .dec_word          (dec_word),
        .dec_valid_out     (dec_valid_out),
        .dec_data          (dec_data),
        .dec_corrected     (dec_corrected),
        .dec_uncorrectable (dec_uncorrectable),
        .dec_syndrome      (dec_syndrome)
    );

    function automatic logic [NP:0] model_enc(input logic [DW-1:0] d);
        logic [NP:0] w;
        logic c;
        w = '0;
        for (int i = 0; i < DW; i++) w[pos_tab[i]] = d[i];
        for (int k = 0; k < CW; k++) begin
            c = 1'b0;
            for (int i = 0; i < DW; i++)
                if (((pos_tab[i] >> k) & 1) == 1) c = c ^ d[i];
            w[1 << k] = c;
        end
        w[0] = ^w[NP:1];
        return w;
    endfunction

    function automatic logic [DW-1:0] model_data(input logic [NP:0] w);
        logic [DW-1:0] d;
        for (int i = 0; i < DW; i++) d[i] = w[pos_tab[i]];
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run_dec(input logic [NP:0] w);
        @(negedge clk);
        dec_word     = w;
        dec_valid_in = 1'b1;
        @(negedge clk);
        dec_valid_in = 1'b0;
        check(dec_valid_out == 1'b1, "R9 valid strobe", 32'(dec_valid_out), 32'd1);
    endtask

    task automatic expect_out(input string req, input logic [DW-1:0] d, input logic corr,
                              input logic unc, input logic [CW-1:0] syn);
        check(dec_data == d, req, 32'(dec_data), 32'(d));
        check(dec_corrected == corr, req, 32'(dec_corrected), 32'(corr));
        check(dec_uncorrectable == unc, req, 32'(dec_uncorrectable), 32'(unc));
        check(dec_syndrome == syn, req, 32'(dec_syndrome), 32'(syn));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(dec_valid_out == 1'b0, "R10 valid", 32'(dec_valid_out), 0);
        expect_out("R10 outputs", '0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_encode();
        logic [DW-1:0] pats [6] = '{8'h00, 8'hFF, 8'h39, 8'hA5, 8'h01, 8'h80};
        foreach (pats[i]) begin
            @(negedge clk);
            enc_data = pats[i];
            #1;
            check(enc_word == model_enc(pats[i]), "R1 R2 layout",
                  32'(enc_word), 32'(model_enc(pats[i])));
            check((^enc_word) == 1'b0, "R3 even weight", 32'(^enc_word), 0);
        end
        enc_data = 8'hFF;
        #1;
        check(enc_word == 13'h1EEE, "R1 known word", 32'(enc_word), 32'h1EEE);
    endtask

    task automatic t_clean();
        logic [DW-1:0] pats [4] = '{8'h00, 8'h39, 8'hC3, 8'hFF};
        foreach (pats[i]) begin
            run_dec(model_enc(pats[i]));
            expect_out("R4 clean", pats[i], 1'b0, 1'b0, '0);
        end
    endtask

    task automatic t_single();
        logic [DW-1:0] pats [2] = '{8'h39, 8'hC3};
        foreach (pats[i]) begin
            for (int p = 1; p <= NP; p++) begin
                run_dec(model_enc(pats[i]) ^ (13'd1 << p));
                expect_out("R5 single", pats[i], 1'b1, 1'b0, CW'(p));
            end
        end
    endtask

    task automatic t_parbit();
        run_dec(model_enc(8'h5A) ^ 13'd1);
        expect_out("R6 parity bit", 8'h5A, 1'b1, 1'b0, '0);
    endtask

    task automatic t_double();
        int pa [4] = '{3, 1, 6, 0};
        int pb [4] = '{5, 2, 12, 7};
        logic [NP:0] w;
        for (int i = 0; i < 4; i++) begin
            w = model_enc(8'h96) ^ (13'd1 << pa[i]) ^ (13'd1 << pb[i]);
            run_dec(w);
            expect_out("R7 double", model_data(w), 1'b0, 1'b1, CW'(pa[i] ^ pb[i]));
        end
    endtask

    task automatic t_range();
        int pa [3] = '{1, 2, 3};
        logic [NP:0] w;
        for (int i = 0; i < 3; i++) begin
            w = model_enc(8'h3C) ^ (13'd1 << pa[i]) ^ (13'd1 << 12) ^ 13'd1;
            run_dec(w);
            expect_out("R8 range", model_data(w), 1'b0, 1'b1, CW'(pa[i] ^ 12));
        end
    endtask

    task automatic t_hold();
        run_dec(model_enc(8'h3A) ^ (13'd1 << 9));
        @(negedge clk);
        dec_word = model_enc(8'hFF) ^ 13'h3;
        repeat (3) begin
            @(negedge clk);
            check(dec_valid_out == 1'b0, "R9 idle valid", 32'(dec_valid_out), 0);
            expect_out("R9 hold", 8'h3A, 1'b1, 1'b0, 4'd9);
        end
    endtask

    initial begin
        t_reset();
        t_encode();
        t_clean();
        t_single();
        t_parbit();
        t_double();
        t_range();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule